// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a core's commit stage and a single memory write port. Every store that reaches it has already been committed, and it carries an address, an 8-byte data word, byte enables and a flag that selects write-combining or ordinary handling. Write-combining stores are gathered into one aligned 64-byte line register. The line is emitted as one full-line transaction once all of its bytes are written, or as a partial transaction with its byte mask when it has to be evicted early. Ordinary stores go through an in-order queue and leave one at a time.

Because a combining line waits for its remaining bytes, ordinary stores committed after it can reach memory first. Ordinary stores never reorder among themselves. A fence input pushes out any partial line and then everything still queued, and it reports completion with a one-cycle done pulse.

Top module: `wc_store_buf`

## Requirements
- R1: Write-combining stores to the same 64-byte line merge into the line register and produce no port transaction of their own.
- R2: When every byte of the buffered line has been written, the line leaves as one transaction with mask all ones and a line-aligned address (low 6 bits zero).
- R3: An ordinary store leaves as one transaction. Its address is the store address with the low 6 bits cleared. The data word sits at byte lane 8*addr[5:3] of the 512-bit data bus. The mask is the byte-enable shifted left by 8*addr[5:3]. Address bits [2:0] are ignored.
- R4: Ordinary stores appear on the port in the order they were accepted.
- R5: An ordinary store accepted after a partial combining line reaches the port while that line is still held.
- R6: A write-combining store to a line other than the buffered one is held off. The buffered line is emitted as a partial write carrying its accumulated mask, and the new store then opens a new line.
- R7: When a byte of the buffered line is written more than once, the last value written is emitted.
- R8: When the port is free, a full or forced line takes precedence over a queued ordinary store.
- R9: The queue holds 8 ordinary stores behind the one on the port. With the port stalled, the ninth unsent store is the last one accepted and st_ready is low after it.
- R10: While a forced partial flush waits for the port, st_ready is low for all stores.
- R11: After fence_req, st_ready stays low while the block drains. The partial line goes out first, then the queued ordinary stores (a transaction already on the port completes before either). fence_done pulses once the port is idle.
- R12: While mem_valid is high and mem_ready is low, the port payload holds steady.
- R13: Only stores taken with st_valid and st_ready both high ever reach the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Committed store offered |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Byte address of the store |
| st_data | input | 8*WORD_BYTES | Store data word |
| st_be | input | WORD_BYTES | Byte enables within the word |
| st_wc | input | 1 | High for write-combining memory type |
| fence_req | input | 1 | One-cycle drain request |
| fence_done | output | 1 | One-cycle pulse when the drain is complete |
| mem_valid | output | 1 | Port transaction valid |
| mem_ready | input | 1 | Memory accepts the transaction |
| mem_addr | output | ADDR_W | Line-aligned address |
| mem_data | output | 8*LINE_BYTES | Line data |
| mem_mask | output | LINE_BYTES | Byte mask |

## Verification
The bench builds the block at its default sizes: 32-bit addresses, a 64-byte line, 8-byte words and an 8-deep queue. With an 8-deep queue, a stalled port fills it in nine stores, so the ready back-pressure boundary is reached directly. With eight words per line, a full-line flush takes only eight stores. Holding mem_ready low lets the bench stack up a stalled ordinary store, a queued one and a full or evicted line, so it can observe the precedence and overtaking orders.

// File: rtl/wcsb_pkg.sv
`timescale 1ns/1ps
package wcsb_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_LINE = 2'd1,
    SRC_ORD  = 2'd2
  } src_e;
endpackage

// File: rtl/wcsb_fifo.sv
`timescale 1ns/1ps
module wcsb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end
  end

  assign dout  = mem[rp[AW-1:0]];
  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/wcsb_line.sv
`timescale 1ns/1ps
module wcsb_line #(
  parameter int TAG_W      = 26,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      wr_en,
  input  logic [TAG_W-1:0]                          wr_tag,
  input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0]  wr_idx,
  input  logic [WORD_BYTES*8-1:0]                   wr_data,
  input  logic [WORD_BYTES-1:0]                     wr_be,
  input  logic                                      clr,
  output logic                                      vld,
  output logic [TAG_W-1:0]                          tag,
  output logic [LINE_BYTES*8-1:0]                   data,
  output logic [LINE_BYTES-1:0]                     mask,
  output logic                                      full
);
  logic [LINE_BYTES-1:0] nb;

  assign nb   = LINE_BYTES'(wr_be) << (wr_idx * WORD_BYTES);
  assign full = vld && (&mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      tag  <= '0;
      mask <= '0;
    end else if (clr) begin
      vld  <= 1'b0;
      mask <= '0;
    end else if (wr_en) begin
      vld  <= 1'b1;
      tag  <= wr_tag;
      mask <= (vld ? mask : '0) | nb;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (wr_en && nb[b]) data[b*8 +: 8] <= wr_data[(b % WORD_BYTES)*8 +: 8];
    end
  end

  a_r6_same_line: assert property (@(posedge clk) disable iff (rst)
    (vld && wr_en) |-> (wr_tag == tag));
endmodule

// File: rtl/wc_store_buf.sv
`timescale 1ns/1ps
module wc_store_buf
  import wcsb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int Q_DEPTH    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [WORD_BYTES*8-1:0] st_data,
  input  logic [WORD_BYTES-1:0]   st_be,
  input  logic                    st_wc,
  input  logic                    fence_req,
  output logic                    fence_done,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_data,
  output logic [LINE_BYTES-1:0]   mem_mask
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BO_W   = $clog2(WORD_BYTES);
  localparam int WI_W   = OFF_W - BO_W;
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int WORD_W = WORD_BYTES * 8;
  localparam int NWORDS = LINE_BYTES / WORD_BYTES;
  localparam int ENT_W  = TAG_W + WI_W + WORD_W + WORD_BYTES;

  logic [TAG_W-1:0] st_tag;
  logic [WI_W-1:0]  st_widx;
  assign st_tag  = st_addr[ADDR_W-1:OFF_W];
  assign st_widx = st_addr[OFF_W-1:BO_W];

  // line register
  logic                    ln_vld, ln_full, ln_wr, take_line;
  logic [TAG_W-1:0]        ln_tag;
  logic [LINE_BYTES*8-1:0] ln_data;
  logic [LINE_BYTES-1:0]   ln_mask;

  // ordinary queue
  logic             q_push, q_pop, q_full, q_empty;
  logic [ENT_W-1:0] q_rd;
  logic [TAG_W-1:0]  q_tag;
  logic [WI_W-1:0]   q_widx;
  logic [WORD_W-1:0] q_data;
  logic [WORD_BYTES-1:0] q_be;
  assign {q_tag, q_widx, q_data, q_be} = q_rd;

  logic force_pend, fence_busy, mismatch, line_out, port_free, acc;
  src_e sel;

  assign mismatch  = st_wc && ln_vld && (st_tag != ln_tag);
  assign line_out  = ln_vld && (ln_full || force_pend);
  assign port_free = !mem_valid || mem_ready;

  always_comb begin
    st_ready = !q_full && !force_pend && !fence_busy && !(st_wc && (line_out || mismatch));
  end

  assign acc    = st_valid && st_ready;
  assign ln_wr  = acc && st_wc;
  assign q_push = acc && !st_wc;

  always_comb begin
    if (!port_free)    sel = SRC_IDLE;
    else if (line_out) sel = SRC_LINE;
    else if (!q_empty) sel = SRC_ORD;
    else               sel = SRC_IDLE;
  end
  assign take_line = (sel == SRC_LINE);
  assign q_pop     = (sel == SRC_ORD);

  wcsb_line #(.TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_line (
    .clk(clk), .rst(rst), .wr_en(ln_wr), .wr_tag(st_tag), .wr_idx(st_widx),
    .wr_data(st_data), .wr_be(st_be), .clr(take_line),
    .vld(ln_vld), .tag(ln_tag), .data(ln_data), .mask(ln_mask), .full(ln_full)
  );

  wcsb_fifo #(.W(ENT_W), .DEPTH(Q_DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(q_push), .din({st_tag, st_widx, st_data, st_be}),
    .pop(q_pop), .dout(q_rd), .full(q_full), .empty(q_empty)
  );

  // control: forced eviction and fence sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      force_pend <= 1'b0;
      fence_busy <= 1'b0;
      fence_done <= 1'b0;
    end else begin
      fence_done <= 1'b0;
      if (take_line)
        force_pend <= 1'b0;
      else if ((st_valid && mismatch) || ((fence_req || fence_busy) && ln_vld))
        force_pend <= 1'b1;
      if (fence_req)
        fence_busy <= 1'b1;
      else if (fence_busy && !ln_vld && q_empty && !mem_valid) begin
        fence_busy <= 1'b0;
        fence_done <= 1'b1;
      end
    end
  end

  // registered port
  always_ff @(posedge clk) begin
    if (rst) mem_valid <= 1'b0;
    else if (port_free) mem_valid <= (sel != SRC_IDLE);
  end

  always_ff @(posedge clk) begin
    if (sel == SRC_LINE) begin
      mem_addr <= {ln_tag, {OFF_W{1'b0}}};
      mem_data <= ln_data;
      mem_mask <= ln_mask;
    end else if (sel == SRC_ORD) begin
      mem_addr <= {q_tag, {OFF_W{1'b0}}};
      mem_data <= {NWORDS{q_data}};
      mem_mask <= LINE_BYTES'(q_be) << (q_widx * WORD_BYTES);
    end
  end

  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_mask) && $stable(mem_data)));
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    fence_done |-> !mem_valid);
endmodule

// File: tb/sim_wc_store_buf.sv
`timescale 1ns/1ps
module sim_wc_store_buf;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic         st_valid = 0, st_ready, st_wc = 0, fence_req = 0, fence_done;
  logic [31:0]  st_addr = 0;
  logic [63:0]  st_data = 0;
  logic [7:0]   st_be = 0;
  logic         mem_valid, mem_ready = 1;
  logic [31:0]  mem_addr;
  logic [511:0] mem_data;
  logic [63:0]  mem_mask;

  wc_store_buf u0 (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_data(st_data), .st_be(st_be), .st_wc(st_wc), .fence_req(fence_req),
    .fence_done(fence_done), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_mask(mem_mask)
  );

  int checks = 0, fails = 0, ln = 0;
  logic [31:0]  la [64];
  logic [511:0] ld [64];
  logic [63:0]  lm [64];

  always begin
    @(negedge clk); #1;
    if (mem_valid && mem_ready && ln < 64) begin
      la[ln] = mem_addr; ld[ln] = mem_data; lm[ln] = mem_mask; ln++;
    end
  end

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be, input logic wc);
    logic ok;
    @(negedge clk);
    st_valid = 1; st_addr = a; st_data = d; st_be = be; st_wc = wc;
    do begin
      #1; ok = st_ready;
      @(posedge clk);
      if (!ok) @(negedge clk);
    end while (!ok);
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fence(output int got);
    int k;
    @(negedge clk); fence_req = 1;
    @(negedge clk); fence_req = 0;
    #1; chk("R11 ready low during fence", 512'(st_ready), 512'(0));
    got = 0;
    for (k = 0; k < 100 && !got; k++) begin
      @(negedge clk); #1;
      if (fence_done) got = 1;
    end
  endtask

  task automatic t_reset;
    chk("R13 reset mem_valid", 512'(mem_valid), 512'(0));
    chk("R9 reset st_ready", 512'(st_ready), 512'(1));
    chk("R11 reset fence_done", 512'(fence_done), 512'(0));
  endtask

  task automatic t_full_line;
    int b = ln;
    for (int i = 0; i < 8; i++) push(32'h1000 + 32'(i*8), 64'hA000_0000_0000_0000 + 64'(i), 8'hFF, 1);
    idle(10);
    chk("R1 one transaction", 512'(ln - b), 512'(1));
    chk("R2 full mask", 512'(lm[b]), 512'({64{1'b1}}));
    chk("R2 aligned addr", 512'(la[b]), 512'(32'h1000));
    for (int i = 0; i < 8; i++)
      chk("R1 merged word", 512'(ld[b][i*64 +: 64]), 512'(64'hA000_0000_0000_0000 + 64'(i)));
  endtask

  task automatic t_order;
    int b = ln;
    @(negedge clk); st_valid = 0; st_addr = 32'h5555; st_wc = 0; st_be = 8'hFF;
    idle(5);
    chk("R13 no accept without valid", 512'(ln - b), 512'(0));
    push(32'h2008, 64'h1111_2222_3333_4444, 8'h0F, 0);
    push(32'h3010, 64'h5555_6666_7777_8888, 8'hFF, 0);
    push(32'h2005, 64'h9999_AAAA_BBBB_CCCC, 8'hF0, 0);
    idle(8);
    chk("R13 count", 512'(ln - b), 512'(3));
    chk("R4 first", 512'(la[b]), 512'(32'h2000));
    chk("R4 second", 512'(la[b+1]), 512'(32'h3000));
    chk("R3 low addr bits dropped", 512'(la[b+2]), 512'(32'h2000));
    chk("R3 mask lane", 512'(lm[b]), 512'(64'h0F << 8));
    chk("R3 data lane", 512'(ld[b][64 +: 64]), 512'(64'h1111_2222_3333_4444));
    chk("R3 mask lane word0", 512'(lm[b+2]), 512'(64'hF0));
  endtask

  task automatic t_overtake;
    int b = ln, got;
    push(32'h4000, 64'hDEAD_BEEF_0000_0001, 8'hFF, 1);
    push(32'h5000, 64'h0000_0000_0000_0002, 8'hFF, 0);
    idle(10);
    chk("R5 ordinary first", 512'(ln - b), 512'(1));
    chk("R5 ordinary addr", 512'(la[b]), 512'(32'h5000));
    fence(got);
    chk("R11 done seen", 512'(got), 512'(1));
    chk("R11 line drained at done", 512'(ln - b), 512'(2));
    chk("R11 partial addr", 512'(la[b+1]), 512'(32'h4000));
    chk("R11 partial mask", 512'(lm[b+1]), 512'(64'hFF));
  endtask

  task automatic t_switch;
    int b = ln, got;
    push(32'h6000, 64'h1111_1111_2222_2222, 8'hFF, 1);
    push(32'h6000, 64'h3333_3333_4444_4444, 8'h0F, 1);
    push(32'h6010, 64'h5555_5555_5555_5555, 8'hFF, 1);
    push(32'h7008, 64'h7777_7777_7777_7777, 8'hFF, 1);
    idle(8);
    chk("R6 old line evicted", 512'(ln - b), 512'(1));
    chk("R6 old addr", 512'(la[b]), 512'(32'h6000));
    chk("R6 accumulated mask", 512'(lm[b]), 512'(64'h00FF_00FF));
    chk("R7 last write wins", 512'(ld[b][63:0]), 512'(64'h1111_1111_4444_4444));
    fence(got);
    chk("R6 new line opened", 512'(la[b+1]), 512'(32'h7000));
    chk("R6 new mask", 512'(lm[b+1]), 512'(64'hFF00));
  endtask

  task automatic t_queue_full;
    int b = ln, n = 0;
    logic [31:0] a0;
    @(negedge clk); mem_ready = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      st_valid = 1; st_wc = 0; st_be = 8'hFF; st_addr = 32'h10000 + 32'(i*64); st_data = 64'(i);
      #1;
      if (!st_ready) break;
      @(posedge clk); n++;
    end
    chk("R9 accepted before full", 512'(n), 512'(9));
    chk("R9 ready low when full", 512'(st_ready), 512'(0));
    @(negedge clk); st_valid = 0;
    #1; a0 = mem_addr;
    idle(3); #1;
    chk("R12 valid held", 512'(mem_valid), 512'(1));
    chk("R12 addr held", 512'(mem_addr), 512'(a0));
    @(negedge clk); mem_ready = 1;
    idle(15);
    chk("R9 all drained", 512'(ln - b), 512'(9));
    for (int i = 0; i < 9; i++) chk("R4 queue order", 512'(la[b+i]), 512'(32'h10000 + 32'(i*64)));
  endtask

  task automatic t_priority;
    int b = ln;
    @(negedge clk); mem_ready = 0;
    push(32'h8000, 64'h1, 8'hFF, 0);
    push(32'h9000, 64'h2, 8'hFF, 0);
    for (int i = 0; i < 8; i++) push(32'hA000 + 32'(i*8), 64'(i), 8'hFF, 1);
    idle(3);
    @(negedge clk); mem_ready = 1;
    idle(8);
    chk("R8 count", 512'(ln - b), 512'(3));
    chk("R8 stalled first", 512'(la[b]), 512'(32'h8000));
    chk("R8 line before queue", 512'(la[b+1]), 512'(32'hA000));
    chk("R8 line full", 512'(lm[b+1]), 512'({64{1'b1}}));
    chk("R8 queue last", 512'(la[b+2]), 512'(32'h9000));
  endtask

  task automatic t_force_block;
    int b = ln, got;
    @(negedge clk); mem_ready = 0;
    push(32'hB000, 64'h1, 8'hFF, 0);
    push(32'hC000, 64'h2, 8'hFF, 1);
    @(negedge clk);
    st_valid = 1; st_wc = 1; st_addr = 32'hD000; st_be = 8'hFF; st_data = 64'h3;
    #1; chk("R6 other-line store held", 512'(st_ready), 512'(0));
    @(negedge clk); #1;
    chk("R10 ready low while forced", 512'(st_ready), 512'(0));
    st_wc = 0; st_addr = 32'hE000; #1;
    chk("R10 ordinary also held", 512'(st_ready), 512'(0));
    @(negedge clk); st_valid = 0; mem_ready = 1;
    push(32'hD000, 64'h3, 8'hFF, 1);
    fence(got);
    chk("R10 count", 512'(ln - b), 512'(3));
    chk("R10 order a", 512'(la[b]), 512'(32'hB000));
    chk("R10 forced partial", 512'(lm[b+1]), 512'(64'hFF));
    chk("R10 order c", 512'(la[b+2]), 512'(32'hD000));
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    t_reset();
    t_full_line();
    t_order();
    t_overtake();
    t_switch();
    t_queue_full();
    t_priority();
    t_force_block();
    idle(4);
    summary();
  end
endmodule